// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block is a host-side master for a string of identical 18-bit serial converters. The converters are wired as a shift-register chain on three wires: a convert strobe, a serial clock and a single data line that returns to the host. One start request makes the controller do four things in turn. It raises the convert strobe. It waits for the conversions to finish. It clocks the whole chain out. It then hands the received words to the consumer one at a time, each tagged with the position of its converter in the chain.

Two completion modes exist, and the controller picks one per cycle. It does this by the level it puts on the serial clock at the convert rising edge. In timed mode the clock is low at that edge, and the controller waits a fixed maximum conversion time. In busy mode the clock is high at that edge, and the controller waits for the data line to rise. Busy mode adds one leading flag bit to the stream, which the controller discards. The chain length, word width, clock divider, conversion wait, minimum cycle time and busy timeout are all parameters.

Top module: `adc_chain_rd`

## Requirements
- R1: While reset is asserted and directly after it, `cnv_o`, `sck_o`, `valid_o` and `tmo_err_o` are low.
- R2: At each rising edge of `cnv_o`, `sck_o` has already been at its cycle's mode level for at least one clock. The level is 0 when `busy_mode_i` was 0 at the start request and 1 when it was 1.
- R3: `cnv_o` stays high from its rising edge until after the last serial-clock falling edge of the readback. It is low whenever `valid_o` is high.
- R4: In timed mode the first rising edge of `sck_o` comes at least `CONV_CYC` clock cycles after the rising edge of `cnv_o`.
- R5: In busy mode no rising edge of `sck_o` occurs after `cnv_o` rises until `sdi_i` has risen. Readback then starts.
- R6: A readback has exactly `N_DEV*WORD_W` serial-clock pulses in timed mode and `N_DEV*WORD_W+1` in busy mode.
- R7: `sdi_i` is sampled just before each falling edge of `sck_o`. The first `WORD_W` data bits form channel 0 (the converter nearest the host), MSB first, then channel 1, and so on. In busy mode the first sampled bit is the busy flag and is dropped.
- R8: Words appear on `data_o`/`chan_o` with `valid_o` in channel order 0 to `N_DEV-1`. While `valid_o` is high and `ready_i` is low, the word and channel hold steady. `valid_o` drops after the last channel is accepted.
- R9: Rising edges of `cnv_o` are at least `CYCLE_MIN` clock cycles apart. A start request that arrives during an active cycle is remembered. It launches exactly one new cycle within 4 clocks after the minimum has elapsed, and not before the current words are delivered.
- R10: In busy mode, if `sdi_i` does not rise within `BUSY_TMO` cycles of waiting, `tmo_err_o` pulses high for one clock. `cnv_o` drops, no words are emitted, and the next request runs normally.
- R11: During readback each high phase and each low phase of `sck_o` lasts at least `SCK_HALF` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and readback cycle |
| busy_mode_i | input | 1 | 1 selects busy-flag completion, 0 selects timed completion; sampled at launch |
| sdi_i | input | 1 | Serial data from the converter nearest the host |
| cnv_o | output | 1 | Convert strobe to all converters |
| sck_o | output | 1 | Serial clock to all converters |
| data_o | output | WORD_W | Received signed result word |
| chan_o | output | max(1,clog2(N_DEV)) | Chain position of `data_o`, 0 = nearest |
| valid_o | output | 1 | `data_o`/`chan_o` are valid |
| ready_i | input | 1 | Consumer accepts the current word |
| tmo_err_o | output | 1 | One-clock pulse when the busy flag never arrived |

## Verification
A behavioural model of the chain loads per-cycle word sets. These include the two extreme codes, alternating bit patterns, small ascending values and irregular values. A bit swap, a lost bit, a wrong word order or a bad sign bit would each corrupt a different one of these sets. The same sets run in timed mode and in busy mode with short, medium and long busy delays. This separates a failure to drop the leading flag, or a clock count that is off by one, from plain shifting errors. Different consumer stall lengths per channel show that words are held and not skipped. A start request placed during readback and a busy flag that never arrives cover the hold-off and timeout paths.

// File: rtl/adc_chain_pkg.sv
`timescale 1ns/1ps
package adc_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_LAUNCH,
    ST_WAIT,
    ST_READ,
    ST_TAIL,
    ST_EMIT
  } chain_st_e;

endpackage

// File: rtl/adc_sck_gen.sv
`timescale 1ns/1ps
module adc_sck_gen #(
  parameter int SCK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(SCK_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o  = ph_q;
  // strobe on the clock that ends a high phase: sample, then drive low
  assign fall_o = en_i & ph_q & wrap;
endmodule

// File: rtl/adc_chain_deser.sv
`timescale 1ns/1ps
module adc_chain_deser #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 18,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [CH_W-1:0]   sel_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int NB = N_DEV * WORD_W;

  logic [NB-1:0]     sr_q;
  logic [WORD_W-1:0] words [N_DEV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[NB-2:0], bit_i};
  end

  // nearest converter arrives first and ends up at the top of the register
  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    assign words[k] = sr_q[(N_DEV-k)*WORD_W-1 -: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < N_DEV; k++)
      if (sel_i == CH_W'(k)) word_o = words[k];
  end
endmodule

// File: rtl/adc_chain_rd.sv
`timescale 1ns/1ps
module adc_chain_rd
  import adc_chain_pkg::*;
#(
  parameter int N_DEV     = 4,
  parameter int WORD_W    = 18,
  parameter int SCK_HALF  = 2,
  parameter int CONV_CYC  = 100,
  parameter int CYCLE_MIN = 150,
  parameter int BUSY_TMO  = 400,
  localparam int CH_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     busy_mode_i,
  input  logic                     sdi_i,
  output logic                     cnv_o,
  output logic                     sck_o,
  output logic signed [WORD_W-1:0] data_o,
  output logic [CH_W-1:0]          chan_o,
  output logic                     valid_o,
  input  logic                     ready_i,
  output logic                     tmo_err_o
);
  localparam int NBITS = N_DEV * WORD_W;
  localparam int BC_W  = $clog2(NBITS + 2);
  localparam int WMAX  = (CONV_CYC > BUSY_TMO) ? CONV_CYC : BUSY_TMO;
  localparam int WC_W  = $clog2(WMAX + 1);
  localparam int GC_W  = $clog2(CYCLE_MIN + 1);

  chain_st_e         st_q;
  logic              mode_q, pend_q, sdi_q, err_q;
  logic [WC_W-1:0]   wcnt_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [GC_W-1:0]   gap_q;
  logic [CH_W-1:0]   ch_q;

  logic              go, busy_rise, gen_sck, sck_fall, shift;
  logic [BC_W-1:0]   last_idx;
  logic [WORD_W-1:0] word;

  assign go        = (st_q == ST_IDLE) && (pend_q || start_i) && (gap_q == GC_W'(CYCLE_MIN));
  assign busy_rise = sdi_i & ~sdi_q;
  assign last_idx  = mode_q ? BC_W'(NBITS) : BC_W'(NBITS - 1);
  assign shift     = sck_fall && !(mode_q && (bcnt_q == '0));

  adc_sck_gen #(.SCK_HALF(SCK_HALF)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_READ),
    .sck_o  (gen_sck),
    .fall_o (sck_fall)
  );

  adc_chain_deser #(.N_DEV(N_DEV), .WORD_W(WORD_W), .CH_W(CH_W)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (sdi_i),
    .sel_i   (ch_q),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      pend_q <= 1'b0;
      sdi_q  <= 1'b0;
      err_q  <= 1'b0;
      wcnt_q <= '0;
      bcnt_q <= '0;
      gap_q  <= GC_W'(CYCLE_MIN);
      ch_q   <= '0;
    end else begin
      sdi_q <= sdi_i;
      err_q <= 1'b0;
      // cycle-time counter restarts on the edge that raises convert
      if (st_q == ST_ARM)                     gap_q <= '0;
      else if (gap_q != GC_W'(CYCLE_MIN))     gap_q <= gap_q + 1'b1;
      if (go)           pend_q <= 1'b0;
      else if (start_i) pend_q <= 1'b1;

      case (st_q)
        ST_IDLE: if (go) begin
          st_q   <= ST_ARM;
          mode_q <= busy_mode_i;
        end
        ST_ARM:    st_q <= ST_LAUNCH;
        ST_LAUNCH: begin
          st_q   <= ST_WAIT;
          wcnt_q <= '0;
        end
        ST_WAIT: begin
          if (!mode_q) begin
            if (wcnt_q == WC_W'(CONV_CYC - 1)) begin
              st_q   <= ST_READ;
              bcnt_q <= '0;
            end else wcnt_q <= wcnt_q + 1'b1;
          end else if (busy_rise) begin
            st_q   <= ST_READ;
            bcnt_q <= '0;
          end else if (wcnt_q == WC_W'(BUSY_TMO - 1)) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end else wcnt_q <= wcnt_q + 1'b1;
        end
        ST_READ: if (sck_fall) begin
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == last_idx) st_q <= ST_TAIL;
        end
        ST_TAIL: begin
          st_q <= ST_EMIT;
          ch_q <= '0;
        end
        ST_EMIT: if (ready_i) begin
          if (ch_q == CH_W'(N_DEV - 1)) st_q <= ST_IDLE;
          else                          ch_q <= ch_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o     = (st_q == ST_LAUNCH) || (st_q == ST_WAIT) ||
                     (st_q == ST_READ)   || (st_q == ST_TAIL);
  // mode level is set up one clock before convert rises and held through it
  assign sck_o     = ((st_q == ST_ARM) || (st_q == ST_LAUNCH)) ? mode_q : gen_sck;
  assign valid_o   = (st_q == ST_EMIT);
  assign data_o    = word;
  assign chan_o    = ch_q;
  assign tmo_err_o = err_q;
endmodule

// File: rtl/adc_chain_rd_chk.sv
`timescale 1ns/1ps
module adc_chain_rd_chk #(
  parameter int N_DEV     = 4,
  parameter int WORD_W    = 18,
  parameter int CYCLE_MIN = 150,
  parameter int CH_W      = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnv_o,
  input logic              sck_o,
  input logic              valid_o,
  input logic              ready_i,
  input logic [WORD_W-1:0] data_o,
  input logic [CH_W-1:0]   chan_o,
  input logic              tmo_err_o
);
  localparam int GW = $clog2(CYCLE_MIN + 1);

  logic          cnv_d;
  logic [GW-1:0] g_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_d <= 1'b0;
      g_q   <= GW'(CYCLE_MIN);
    end else begin
      cnv_d <= cnv_o;
      if (cnv_o && !cnv_d)           g_q <= GW'(1);
      else if (g_q != GW'(CYCLE_MIN)) g_q <= g_q + 1'b1;
    end
  end

  p_sck_held_at_cnv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> (sck_o == $past(sck_o)));

  p_sck_fall_in_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> cnv_o);

  p_valid_no_cnv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !cnv_o);

  p_valid_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(chan_o)));

  p_chan_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(chan_o) < N_DEV));

  p_cnv_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_o && !cnv_d) |-> (g_q >= GW'(CYCLE_MIN)));

  p_err_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |-> (!cnv_o && !valid_o));

  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |=> !tmo_err_o);
endmodule

bind adc_chain_rd adc_chain_rd_chk #(
  .N_DEV(N_DEV), .WORD_W(WORD_W), .CYCLE_MIN(CYCLE_MIN), .CH_W(CH_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnv_o     (cnv_o),
  .sck_o     (sck_o),
  .valid_o   (valid_o),
  .ready_i   (ready_i),
  .data_o    (data_o),
  .chan_o    (chan_o),
  .tmo_err_o (tmo_err_o)
);

// File: tb/adc_chain_rd_bench.sv
`timescale 1ns/1ps
module adc_chain_rd_bench;
  localparam int N    = 4;
  localparam int W    = 18;
  localparam int HALF = 2;
  localparam int CONV = 100;
  localparam int CMIN = 600;
  localparam int TMO  = 300;
  localparam int NB   = N * W;
  localparam real TCK = 5.0;

  // vector table: completion mode, busy delay (clocks), chain words (channel 0 in top bits)
  localparam int NV = 6;
  localparam bit VB [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int VD [NV] = '{0, 120, 0, 250, 60, 0};
  localparam logic [NB-1:0] VW [NV] = '{
    {18'h20000, 18'h1FFFF, 18'h00000, 18'h3FFFF},
    {18'h2AAAA, 18'h15555, 18'h2AAAA, 18'h15555},
    {18'h00001, 18'h00002, 18'h00003, 18'h00004},
    {18'h3FFFF, 18'h3FFFE, 18'h20001, 18'h1FFFE},
    {18'h12345, 18'h0ABCD, 18'h3C3C3, 18'h00F0F},
    {18'h15555, 18'h2AAAA, 18'h00000, 18'h20000}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic busy_mode_i = 1'b0;
  logic ready_i = 1'b0;
  logic sdi_i;
  logic cnv_o, sck_o, valid_o, tmo_err_o;
  logic signed [W-1:0] data_o;
  logic [1:0] chan_o;

  always #2.5 clk_i = ~clk_i;

  adc_chain_rd #(
    .N_DEV(N), .WORD_W(W), .SCK_HALF(HALF), .CONV_CYC(CONV),
    .CYCLE_MIN(CMIN), .BUSY_TMO(TMO)
  ) u_adc_chain_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_mode_i(busy_mode_i),
    .sdi_i(sdi_i), .cnv_o(cnv_o), .sck_o(sck_o), .data_o(data_o), .chan_o(chan_o),
    .valid_o(valid_o), .ready_i(ready_i), .tmo_err_o(tmo_err_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // chain model
  logic [NB:0]   sh = '0;
  logic [NB-1:0] cur_words = '0;
  bit   armed = 1'b0, m_mode = 1'b0;
  int   m_cnt = 0, m_delay = 0, n_launch = 0, n_sck = 0, viol = 0;
  realtime cnv_t = 0, prev_t = 0, gap_t = 0, busy_t = 0, first_t = 0, rise_t = 0, fall_t = 0;

  assign sdi_i = sh[NB];

  always @(posedge cnv_o) begin
    m_mode = sck_o;
    prev_t = cnv_t;
    cnv_t  = $realtime;
    gap_t  = cnv_t - prev_t;
    m_cnt  = 0;
    n_launch++;
    if (m_mode) begin
      sh = '0;
      armed = 1'b0;
    end else begin
      sh = {cur_words, 1'b0};
      armed = 1'b1;
    end
  end

  always @(negedge clk_i) begin
    if (cnv_o && !armed && m_mode) begin
      m_cnt++;
      if (m_cnt == m_delay) begin
        sh = {1'b1, cur_words};
        armed = 1'b1;
        busy_t = $realtime;
      end
    end
  end

  always @(negedge sck_o) begin
    if (cnv_o) begin
      if (rise_t > cnv_t && ($realtime - rise_t) < HALF * TCK) viol++;
      fall_t = $realtime;
      if (armed) sh = {sh[NB-1:0], 1'b0};
    end
  end

  always @(posedge sck_o) begin
    if (cnv_o) begin
      n_sck++;
      if (rise_t < cnv_t) first_t = $realtime;
      if (fall_t > cnv_t && ($realtime - fall_t) < HALF * TCK) viol++;
      rise_t = $realtime;
    end
  end

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  // one cycle: optional launch, optional extra request during readback, then collect words
  task automatic do_cycle(input bit b, input int d, input logic [NB-1:0] w,
                          input bit extra, input bit no_start);
    int s0, v0, l0, waited;
    s0 = n_sck; v0 = viol; l0 = n_launch;
    cur_words = w; m_delay = d; busy_mode_i = b;
    if (!no_start) pulse_start();
    if (extra) begin
      waited = 0;
      while (n_sck < s0 + 10 && waited < 4000) begin @(negedge clk_i); waited++; end
      pulse_start();
    end
    waited = 0;
    while (!valid_o && waited < 4000) begin @(negedge clk_i); waited++; end
    chk(valid_o, "R8 words delivered", valid_o, 1);
    chk(n_launch == l0 + 1, "R9 single launch before delivery", n_launch - l0, 1);
    chk(m_mode == b, "R2 clock level at convert edge", m_mode, b);
    chk(n_sck - s0 == NB + b, "R6 clock pulse count", n_sck - s0, NB + b);
    chk(viol == v0, "R11 clock phase width", viol - v0, 0);
    chk(!cnv_o, "R3 convert low when words valid", cnv_o, 0);
    if (!b) chk(first_t - cnv_t >= CONV * TCK, "R4 timed wait before clocking",
                longint'((first_t - cnv_t) / TCK), CONV);
    else    chk(first_t > busy_t, "R5 clocking only after busy flag",
                longint'((first_t - busy_t) / TCK), 1);
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] exp_w;
      exp_w = w[NB-1-k*W -: W];
      chk(valid_o && chan_o == 2'(k), "R8 channel order", chan_o, k);
      chk(data_o == exp_w, "R7 word contents", data_o, exp_w);
      for (int s = 0; s < k; s++) begin
        @(negedge clk_i);
        chk(valid_o && data_o == exp_w && chan_o == 2'(k), "R8 hold under stall", data_o, exp_w);
      end
      ready_i = 1'b1;
      @(negedge clk_i);
      ready_i = 1'b0;
    end
    chk(!valid_o, "R8 valid drops after last channel", valid_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int waited;
    bit seen;
    int l0;
    repeat (3) @(negedge clk_i);
    chk(!cnv_o && !sck_o && !valid_o && !tmo_err_o, "R1 outputs low in reset",
        {cnv_o, sck_o, valid_o, tmo_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cnv_o && !sck_o && !valid_o && !tmo_err_o, "R1 outputs low after reset",
        {cnv_o, sck_o, valid_o, tmo_err_o}, 0);

    for (int i = 0; i < NV; i++) do_cycle(VB[i], VD[i], VW[i], 1'b0, 1'b0);

    // R9: request during readback is held off, then launched once the minimum passes
    do_cycle(1'b0, 0, VW[3], 1'b1, 1'b0);
    do_cycle(1'b0, 0, VW[3], 1'b0, 1'b1);
    chk(gap_t >= CMIN * TCK && gap_t <= (CMIN + 4) * TCK, "R9 held request launch spacing",
        longint'(gap_t / TCK), CMIN + 2);
    l0 = n_launch;
    repeat (CMIN + 20) @(negedge clk_i);
    chk(n_launch == l0, "R9 held request launches only once", n_launch - l0, 0);

    // R10: busy flag never arrives
    cur_words = VW[0]; m_delay = 1000000; busy_mode_i = 1'b1;
    l0 = n_launch;
    pulse_start();
    seen = 1'b0; waited = 0;
    while (!seen && waited < TMO + 50) begin
      @(negedge clk_i);
      waited++;
      if (tmo_err_o) seen = 1'b1;
    end
    chk(seen, "R10 timeout pulse", seen, 1);
    chk(!cnv_o, "R10 convert dropped on timeout", cnv_o, 0);
    @(negedge clk_i);
    chk(!tmo_err_o, "R10 timeout pulse one clock", tmo_err_o, 0);
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk_i);
      if (valid_o) seen = 1'b1;
    end
    chk(!seen, "R10 no words after timeout", seen, 0);
    chk(n_launch == l0 + 1, "R10 single launch for timed-out cycle", n_launch - l0, 1);
    do_cycle(1'b1, 120, VW[4], 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule